// File: doc/BRIEF.md
# Staged Control Decoder for a Five-Stage Pipeline

This block sits at the decode stage of a five-stage in-order pipeline. It holds the fetch-to-decode instruction register and decodes that instruction's opcode into the usual control set. It then carries each control group forward through staged registers, so that every signal arrives at the stage that consumes it. Execute controls pass through one register, memory controls through two, and write-back controls through three. The sign-extended immediate is registered once with the execute group, and the ALU function code is taken from the low six bits of that registered immediate.

Inside the block, a signal's depth is visible from its name. A decoded value that still has to cross n registers carries n leading `d` letters. The fully registered value keeps the plain name, and that plain name is the port. All storage updates on the rising clock edge. Reset is synchronous and active high. It clears every control register and loads the instruction register with all zeros, which is a shift of register zero into itself and changes no state. No hazard detection, forwarding or flushing is present, so the instruction stream must be free of hazards.

Top module: `ctl_stage_chain`

## Requirements
- R1: On each rising edge without reset, `id_instr` takes the value of `fetch_instr`. A rising edge with `rst` high loads `id_instr` with 32'h00000000.
- R2: The opcode is `id_instr[31:26]`, and the decode table is fixed:
  - Opcode 6'h00 (register type) sets reg_dst=1, reg_write=1 and alu_op=2'b10.
  - Opcode 6'h23 (load) sets alu_src=1, mem_read=1, reg_write=1, mem_to_reg=1 and alu_op=2'b00.
  - Opcode 6'h2B (store) sets alu_src=1, mem_write=1 and alu_op=2'b00.
  - Opcode 6'h04 (branch-if-equal) sets branch=1 and alu_op=2'b01.
  - Every control not listed for an opcode is 0.
- R3: `reg_dst`, `alu_src` and `alu_op` show the decode of an instruction exactly one rising edge after that instruction appears on `id_instr`.
- R4: `branch`, `mem_read` and `mem_write` show that decode exactly two rising edges after it appears on `id_instr`.
- R5: `reg_write` and `mem_to_reg` show that decode exactly three rising edges after it appears on `id_instr`.
- R6: One edge after an instruction appears on `id_instr`, `ex_imm` holds the sign extension of `id_instr[15:0]` and `ex_funct` equals `ex_imm[5:0]`.
- R7: A rising edge with `rst` high clears all control outputs and `ex_imm` to zero.
- R8: For the first two rising edges after `rst` is released, `reg_write` and `mem_write` stay 0 whatever instructions are fetched.
- R9: Any opcode other than 6'h00, 6'h23, 6'h2B and 6'h04 decodes to all controls 0, and alu_op is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_instr | input | 32 | Instruction from the fetch stage |
| id_instr | output | 32 | Fetch-to-decode instruction register |
| ex_imm | output | 32 | Registered sign-extended immediate for execute |
| ex_funct | output | 6 | ALU function code, low bits of `ex_imm` |
| reg_dst | output | 1 | Execute: destination taken from the rd field |
| alu_src | output | 1 | Execute: second ALU operand is the immediate |
| alu_op | output | 2 | Execute: ALU operation class |
| branch | output | 1 | Memory stage: conditional branch |
| mem_read | output | 1 | Memory stage: data read enable |
| mem_write | output | 1 | Memory stage: data write enable |
| reg_write | output | 1 | Write-back: register file write enable |
| mem_to_reg | output | 1 | Write-back: result comes from memory |

## Verification
An instruction driven on `fetch_instr` before edge k is visible on `id_instr` after edge k. Its execute controls, `ex_imm` and `ex_funct` follow after edge k+1, its memory controls after edge k+2, and its write-back controls after edge k+3. The bench keeps its own record of the last fetched instructions and of whether reset was asserted at each edge. It samples a quarter period after every edge and compares each group against the decode of the instruction that entered the correct number of edges earlier. All 64 opcodes are swept with varied immediates, and a load, register-type, store sequence is run directly after reset. That sequence shows the write enables held low for the first two edges and each group arriving at its fixed delay.

// File: rtl/ctl_stage_chain.sv
module ctl_stage_chain #(
  parameter int IW  = 32,
  parameter int OPW = 6,
  parameter int IMW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] fetch_instr,
  output logic [IW-1:0] id_instr,
  output logic [IW-1:0] ex_imm,
  output logic [5:0]    ex_funct,
  output logic          reg_dst,
  output logic          alu_src,
  output logic [1:0]    alu_op,
  output logic          branch,
  output logic          mem_read,
  output logic          mem_write,
  output logic          reg_write,
  output logic          mem_to_reg
);
  localparam logic [OPW-1:0] OP_RT = OPW'('h00);
  localparam logic [OPW-1:0] OP_LD = OPW'('h23);
  localparam logic [OPW-1:0] OP_ST = OPW'('h2B);
  localparam logic [OPW-1:0] OP_BR = OPW'('h04);

  wire [OPW-1:0] opc = id_instr[IW-1 -: OPW];
  wire is_rt = (opc == OP_RT);
  wire is_ld = (opc == OP_LD);
  wire is_st = (opc == OP_ST);
  wire is_br = (opc == OP_BR);

  wire          d_reg_dst      = is_rt;
  wire          d_alu_src      = is_ld | is_st;
  wire [1:0]    d_alu_op       = {is_rt, is_br};
  wire [IW-1:0] d_ex_imm       = {{(IW-IMW){id_instr[IMW-1]}}, id_instr[IMW-1:0]};
  wire          dd_branch      = is_br;
  wire          dd_mem_read    = is_ld;
  wire          dd_mem_write   = is_st;
  wire          ddd_reg_write  = is_rt | is_ld;
  wire          ddd_mem_to_reg = is_ld;

  logic d_branch, d_mem_read, d_mem_write;
  logic dd_reg_write, dd_mem_to_reg;
  logic d_reg_write, d_mem_to_reg;

  always_ff @(posedge clk) begin
    if (rst) id_instr <= '0;
    else     id_instr <= fetch_instr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_dst       <= 1'b0;
      alu_src       <= 1'b0;
      alu_op        <= 2'b00;
      ex_imm        <= '0;
      d_branch      <= 1'b0;
      d_mem_read    <= 1'b0;
      d_mem_write   <= 1'b0;
      dd_reg_write  <= 1'b0;
      dd_mem_to_reg <= 1'b0;
    end else begin
      reg_dst       <= d_reg_dst;
      alu_src       <= d_alu_src;
      alu_op        <= d_alu_op;
      ex_imm        <= d_ex_imm;
      d_branch      <= dd_branch;
      d_mem_read    <= dd_mem_read;
      d_mem_write   <= dd_mem_write;
      dd_reg_write  <= ddd_reg_write;
      dd_mem_to_reg <= ddd_mem_to_reg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      branch       <= 1'b0;
      mem_read     <= 1'b0;
      mem_write    <= 1'b0;
      d_reg_write  <= 1'b0;
      d_mem_to_reg <= 1'b0;
    end else begin
      branch       <= d_branch;
      mem_read     <= d_mem_read;
      mem_write    <= d_mem_write;
      d_reg_write  <= dd_reg_write;
      d_mem_to_reg <= dd_mem_to_reg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_write  <= 1'b0;
      mem_to_reg <= 1'b0;
    end else begin
      reg_write  <= d_reg_write;
      mem_to_reg <= d_mem_to_reg;
    end
  end

  assign ex_funct = ex_imm[5:0];
endmodule

// File: rtl/ctl_stage_chain_chk.sv
module ctl_stage_chain_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] fetch_instr,
  input logic [31:0] id_instr,
  input logic [31:0] ex_imm,
  input logic        reg_dst,
  input logic        alu_src,
  input logic [1:0]  alu_op,
  input logic        branch,
  input logic        mem_read,
  input logic        mem_write,
  input logic        reg_write,
  input logic        mem_to_reg
);
  wire [5:0] opc = id_instr[31:26];
  wire undef_op = (opc != 6'h00) && (opc != 6'h23) && (opc != 6'h2B) && (opc != 6'h04);

  a_r1_reset_nop: assert property (@(posedge clk) rst |=> id_instr == 32'h0);
  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> id_instr == $past(fetch_instr));
  a_r3_load_ex: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h23) |=> alu_src && !reg_dst && alu_op == 2'b00);
  a_r4_read_follows_ex: assert property (@(posedge clk) disable iff (rst)
    (alu_src && alu_op == 2'b00 && !reg_dst) |=> (mem_read || mem_write));
  a_r5_wb_follows_mem: assert property (@(posedge clk) disable iff (rst)
    mem_read |=> reg_write && mem_to_reg);
  a_r6_imm_ext: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ex_imm == {{16{$past(id_instr[15])}}, $past(id_instr[15:0])});
  a_r7_clear: assert property (@(posedge clk)
    rst |=> !reg_write && !mem_write && !mem_read && !branch && !reg_dst && !alu_src && alu_op == 2'b00);
  a_r8_quiet_start: assert property (@(posedge clk)
    rst |=> ##1 !reg_write && !mem_write);
  a_r9_undef: assert property (@(posedge clk) disable iff (rst)
    undef_op |=> !reg_dst && !alu_src && alu_op == 2'b00);
endmodule

bind ctl_stage_chain ctl_stage_chain_chk chk_i (
  .clk(clk), .rst(rst), .fetch_instr(fetch_instr), .id_instr(id_instr),
  .ex_imm(ex_imm), .reg_dst(reg_dst), .alu_src(alu_src), .alu_op(alu_op),
  .branch(branch), .mem_read(mem_read), .mem_write(mem_write),
  .reg_write(reg_write), .mem_to_reg(mem_to_reg)
);

// File: tb/ctl_stage_chain_tb_top.sv
module ctl_stage_chain_tb_top;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] fetch_instr = '0;
  logic [31:0] id_instr, ex_imm;
  logic [5:0]  ex_funct;
  logic reg_dst, alu_src, branch, mem_read, mem_write, reg_write, mem_to_reg;
  logic [1:0] alu_op;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ctl_stage_chain dut_i (
    .clk(clk), .rst(rst), .fetch_instr(fetch_instr), .id_instr(id_instr),
    .ex_imm(ex_imm), .ex_funct(ex_funct), .reg_dst(reg_dst), .alu_src(alu_src),
    .alu_op(alu_op), .branch(branch), .mem_read(mem_read), .mem_write(mem_write),
    .reg_write(reg_write), .mem_to_reg(mem_to_reg)
  );

  // {reg_dst, alu_src, alu_op[1:0], branch, mem_read, mem_write, reg_write, mem_to_reg}
  function automatic logic [8:0] expect_ctl(input logic [5:0] op);
    case (op)
      6'h00:   return 9'b1_0_10_000_10;
      6'h23:   return 9'b0_1_00_010_11;
      6'h2B:   return 9'b0_1_00_001_00;
      6'h04:   return 9'b0_0_01_100_00;
      default: return 9'b0;
    endcase
  endfunction

  logic [31:0] m_id = '0;
  logic [31:0] m_imm = '0;
  logic [3:0]  m_ex = '0;
  logic [2:0]  m_exm = '0, m_mem = '0;
  logic [1:0]  m_exw = '0, m_memw = '0, m_wb = '0;
  int since_rel = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic [31:0] ins);
    logic [8:0] dc;
    rst = r;
    fetch_instr = ins;
    @(posedge clk);
    dc = expect_ctl(m_id[31:26]);
    if (r) begin
      m_wb = '0; m_mem = '0; m_memw = '0;
      m_ex = '0; m_exm = '0; m_exw = '0; m_imm = '0; m_id = '0;
      since_rel = 0;
    end else begin
      m_wb = m_memw;
      m_mem = m_exm; m_memw = m_exw;
      m_ex = dc[8:5]; m_exm = dc[4:2]; m_exw = dc[1:0];
      m_imm = {{16{m_id[15]}}, m_id[15:0]};
      m_id = ins;
      since_rel++;
    end
    #(PERIOD/4);
    chk("R1 id_instr", id_instr, m_id);
    chk(r ? "R7 ex group" : "R3 ex group", {28'b0, reg_dst, alu_src, alu_op}, {28'b0, m_ex});
    chk(r ? "R7 mem group" : "R4 mem group", {29'b0, branch, mem_read, mem_write}, {29'b0, m_mem});
    chk(r ? "R7 wb group" : "R5 wb group", {30'b0, reg_write, mem_to_reg}, {30'b0, m_wb});
    chk("R6 ex_imm", ex_imm, m_imm);
    chk("R6 ex_funct", {26'b0, ex_funct}, {26'b0, m_imm[5:0]});
    if (!r && since_rel <= 2)
      chk("R8 quiet start", {30'b0, reg_write, mem_write}, 32'b0);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(1'b1, 32'hFFFF_FFFF);
    step(1'b1, 32'h8C00_0001);
    // R8 / R3 / R4 / R5: load, register type, store right after reset
    step(1'b0, 32'h8C41_0054);
    step(1'b0, 32'h0022_1820);
    step(1'b0, 32'hAC43_0064);
    step(1'b0, 32'h1000_FFFE);
    for (int k = 0; k < 4; k++) step(1'b0, 32'h0);
    // R2 / R9: sweep every opcode with varied low bits
    for (int op = 0; op < 64; op++) begin
      for (int v = 0; v < 3; v++) begin
        logic [25:0] lo;
        lo = (v == 0) ? 26'h000_8000 : (v == 1) ? 26'h3FF_7FFF : 26'h155_A5C3 + 26'(op);
        step(1'b0, {6'(op), lo});
      end
    end
    // R7: reset in mid-stream clears every stage
    step(1'b0, 32'h8C00_0010);
    step(1'b0, 32'hAC00_0020);
    step(1'b1, 32'h8C00_0030);
    step(1'b0, 32'h0000_0000);
    step(1'b0, 32'h8C00_0040);
    for (int k = 0; k < 4; k++) step(1'b0, 32'hAC00_0000);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule